// File: doc/BRIEF.md
# Converter Power-State Sequencer

This controller sits on the host side of a sampling converter that has two shutdown depths. It drives the converter's mode-select line, where high picks the shallow nap state and low picks the deep sleep state, and its active-low shutdown line. It makes sure the mode-select level has settled for a programmable number of clock cycles before the shutdown line falls. While the mode-select line is low, it never lets the shutdown line fall sooner than that.

Wake-up works as follows. The shutdown line is released, and then the sequencer holds back conversion starts until a wake-up delay has run out. Nap and sleep each have their own delay, counted in clock cycles. Nap recovers within a few hundred nanoseconds. Sleep needs milliseconds, because the reference has to settle again. A shutdown request that arrives while a conversion is running is kept and carried out once the converter's busy indication clears. Conversion requests pass through as one-cycle start pulses, but only while the converter is fully awake.

Top module: `adc_pwr_seq`

## Requirements
- R1: After synchronous reset, `shdn_n` is 1, `mode_sel` is 1, `ready` is 1 and `conv_go` is 0.
- R2: A nap request (`req_kind` = 2'b01 with `req_valid` high, converter idle) drives `mode_sel` to 1 and `ready` to 0 on the next edge. `shdn_n` falls exactly `SETUP_CYC` edges after that.
- R3: A sleep request (`req_kind` = 2'b10) drives `mode_sel` to 0 and `ready` to 0 on the next edge. `shdn_n` falls `SETUP_CYC` edges after `mode_sel` changed, and `mode_sel` stays unchanged while `shdn_n` is low.
- R4: A wake request (`req_kind` = 2'b11) while shut down raises `shdn_n` on the next edge. After waking from nap, `ready` rises exactly `NAP_WAKE_CYC` edges after `shdn_n` rose.
- R5: After waking from sleep, `ready` rises exactly `SLEEP_WAKE_CYC` edges after `shdn_n` rose.
- R6: A nap or sleep request seen while `conv_busy` is 1 leaves all outputs unchanged. It is carried out on the first edge at which `conv_busy` is sampled 0, with the same timing as R2/R3 measured from that edge.
- R7: `conv_req` sampled high while `ready` is 1, `conv_busy` is 0 and no shutdown starts at that edge gives `conv_go` = 1 for one cycle on the next edge. Otherwise `conv_go` is 0.
- R8: `conv_req` has no effect (`conv_go` stays 0) while `shdn_n` is low or a wake-up delay is still counting.
- R9: A wake request while awake, and a nap or sleep request while shut down or waking, are ignored and leave `shdn_n`, `mode_sel` and `ready` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Power request strobe |
| req_kind | input | 2 | 01 nap, 10 sleep, 11 wake, 00 none |
| conv_req | input | 1 | Host asks to start a conversion |
| conv_busy | input | 1 | Converter reports a conversion in progress |
| mode_sel | output | 1 | Shutdown depth select, 1 nap, 0 sleep |
| shdn_n | output | 1 | Active-low shutdown line to the converter |
| ready | output | 1 | Converter awake and settled |
| conv_go | output | 1 | One-cycle conversion start permit |

## Verification
The bench builds the block with `SETUP_CYC` = 2, `NAP_WAKE_CYC` = 4 and `SLEEP_WAKE_CYC` = 12 rather than the clock-accurate defaults. With these values, both wake-up windows can be checked at the exact edge where `ready` rises, and at the edge just before it. Because the two delays differ, a swap between the nap and sleep counts shows up as a wrong edge. A setup of two cycles means an off-by-one in the mode-to-shutdown ordering also lands on a visibly wrong cycle.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
  typedef enum logic [1:0] {
    REQ_NONE  = 2'b00,
    REQ_NAP   = 2'b01,
    REQ_SLEEP = 2'b10,
    REQ_WAKE  = 2'b11
  } pwr_req_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_SETUP,
    ST_DOWN,
    ST_WAKE
  } pwr_st_e;
endpackage

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/adc_pwr_hold.sv
module adc_pwr_hold (
  input  logic clk,
  input  logic rst,
  input  logic capture,
  input  logic capture_sleep,
  input  logic clear,
  output logic held,
  output logic held_sleep
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      held       <= 1'b0;
      held_sleep <= 1'b0;
    end else if (capture) begin
      held       <= 1'b1;
      held_sleep <= capture_sleep;
    end
  end
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int SETUP_CYC      = 1,
  parameter int NAP_WAKE_CYC   = 10,
  parameter int SLEEP_WAKE_CYC = 500000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  input  logic       conv_req,
  input  logic       conv_busy,
  output logic       mode_sel,
  output logic       shdn_n,
  output logic       ready,
  output logic       conv_go
);
  localparam int MAX_AB = (NAP_WAKE_CYC > SLEEP_WAKE_CYC) ? NAP_WAKE_CYC : SLEEP_WAKE_CYC;
  localparam int MAX_C  = (SETUP_CYC > MAX_AB) ? SETUP_CYC : MAX_AB;
  localparam int CW     = $clog2(MAX_C + 1);

  pwr_st_e  st;
  pwr_req_e kind;
  logic     req_sd, want_sleep, sd_wanted, start_sd, park, wake_req;
  logic     held, held_sleep, expired, t_load;
  logic [CW-1:0] t_val;

  assign kind       = pwr_req_e'(req_kind);
  assign req_sd     = req_valid && (kind == REQ_NAP || kind == REQ_SLEEP);
  assign want_sleep = req_sd ? (kind == REQ_SLEEP) : held_sleep;
  assign sd_wanted  = req_sd || held;
  assign start_sd   = (st == ST_RUN) && sd_wanted && !conv_busy;
  assign park       = (st == ST_RUN) && sd_wanted && conv_busy;
  assign wake_req   = (st == ST_DOWN) && req_valid && (kind == REQ_WAKE);

  assign t_load = start_sd || wake_req;
  always_comb begin
    if (start_sd)      t_val = CW'(SETUP_CYC - 1);
    else if (mode_sel) t_val = CW'(NAP_WAKE_CYC - 1);
    else               t_val = CW'(SLEEP_WAKE_CYC - 1);
  end

  adc_pwr_timer #(.W(CW)) i_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(expired)
  );

  adc_pwr_hold i_hold (
    .clk(clk), .rst(rst), .capture(park), .capture_sleep(want_sleep),
    .clear(start_sd), .held(held), .held_sleep(held_sleep)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_RUN;
      mode_sel <= 1'b1;
      shdn_n   <= 1'b1;
      ready    <= 1'b1;
      conv_go  <= 1'b0;
    end else begin
      conv_go <= (st == ST_RUN) && conv_req && !conv_busy && !start_sd;
      case (st)
        ST_RUN: if (start_sd) begin
          mode_sel <= !want_sleep;
          ready    <= 1'b0;
          st       <= ST_SETUP;
        end
        ST_SETUP: if (expired) begin
          shdn_n <= 1'b0;
          st     <= ST_DOWN;
        end
        ST_DOWN: if (wake_req) begin
          shdn_n <= 1'b1;
          st     <= ST_WAKE;
        end
        default: if (expired) begin
          ready <= 1'b1;
          st    <= ST_RUN;
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
  parameter int SETUP_CYC      = 1,
  parameter int NAP_WAKE_CYC   = 10,
  parameter int SLEEP_WAKE_CYC = 500000
) (
  input logic clk,
  input logic rst,
  input logic conv_req,
  input logic conv_busy,
  input logic mode_sel,
  input logic shdn_n,
  input logic ready,
  input logic conv_go
);
  logic        ms_prev, sh_prev;
  logic [31:0] ms_age, sh_age;

  always_ff @(posedge clk) begin
    if (rst) begin
      ms_prev <= 1'b1;
      sh_prev <= 1'b1;
      ms_age  <= 32'(SETUP_CYC);
      sh_age  <= 32'(SLEEP_WAKE_CYC + NAP_WAKE_CYC);
    end else begin
      ms_prev <= mode_sel;
      sh_prev <= shdn_n;
      if (mode_sel != ms_prev)     ms_age <= '0;
      else if (ms_age < 32'(SETUP_CYC)) ms_age <= ms_age + 1;
      if (shdn_n != sh_prev)       sh_age <= '0;
      else if (sh_age < 32'(SLEEP_WAKE_CYC + NAP_WAKE_CYC)) sh_age <= sh_age + 1;
    end
  end

  assert_mode_settled_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(shdn_n) |-> (ms_age >= 32'(SETUP_CYC - 1)));

  assert_mode_steady_down_R3: assert property (@(posedge clk) disable iff (rst)
    (!shdn_n && $past(!shdn_n)) |-> $stable(mode_sel));

  assert_ready_awake_R4: assert property (@(posedge clk) disable iff (rst)
    ready |-> shdn_n);

  assert_wake_gap_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (sh_age >= (mode_sel ? 32'(NAP_WAKE_CYC - 1) : 32'(SLEEP_WAKE_CYC - 1))));

  assert_busy_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (conv_busy && ready) |=> ready);

  assert_go_cause_R7: assert property (@(posedge clk) disable iff (rst)
    conv_go |-> ($past(conv_req) && !$past(conv_busy)));

  assert_no_go_asleep_R8: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !conv_go);
endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(
  .SETUP_CYC(SETUP_CYC), .NAP_WAKE_CYC(NAP_WAKE_CYC), .SLEEP_WAKE_CYC(SLEEP_WAKE_CYC)
) i_chk (
  .clk(clk), .rst(rst), .conv_req(conv_req), .conv_busy(conv_busy),
  .mode_sel(mode_sel), .shdn_n(shdn_n), .ready(ready), .conv_go(conv_go)
);

// File: tb/test_adc_pwr_seq.sv
module test_adc_pwr_seq;
  localparam int SETUP = 2;
  localparam int NAPW  = 4;
  localparam int SLPW  = 12;

  typedef struct {
    int    at;
    bit    sh;
    bit    ms;
    bit    rdy;
    bit    go;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic       conv_req = 1'b0;
  logic       conv_busy = 1'b0;
  logic       mode_sel, shdn_n, ready, conv_go;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t q[$];

  adc_pwr_seq #(.SETUP_CYC(SETUP), .NAP_WAKE_CYC(NAPW), .SLEEP_WAKE_CYC(SLPW)) i_adc_pwr_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .conv_req(conv_req), .conv_busy(conv_busy), .mode_sel(mode_sel),
    .shdn_n(shdn_n), .ready(ready), .conv_go(conv_go)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.at != cyc || shdn_n !== e.sh || mode_sel !== e.ms || ready !== e.rdy || conv_go !== e.go) begin
        errors++;
        $display("FAIL %s cyc=%0d: got sh=%b ms=%b rdy=%b go=%b, expected sh=%b ms=%b rdy=%b go=%b (at %0d)",
                 e.tag, cyc, shdn_n, mode_sel, ready, conv_go, e.sh, e.ms, e.rdy, e.go, e.at);
      end
    end
  end

  task automatic exp_at(int at, bit sh, bit ms, bit rdy, bit go, string tag);
    exp_t e;
    e.at = at; e.sh = sh; e.ms = ms; e.rdy = rdy; e.go = go; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic request(logic [1:0] k);
    req_valid = 1'b1;
    req_kind  = k;
  endtask

  task automatic quiet();
    req_valid = 1'b0;
    req_kind  = 2'b00;
    conv_req  = 1'b0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
  end

  initial begin
    int n;
    step(3);
    rst = 1'b0;
    exp_at(cyc + 1, 1, 1, 1, 0, "R1 reset state");
    step(2);

    // R7: permitted start, then a busy converter blocks it
    conv_req = 1'b1; n = cyc;
    exp_at(n + 1, 1, 1, 1, 1, "R7 start pulse");
    step(); quiet();
    exp_at(n + 2, 1, 1, 1, 0, "R7 pulse one cycle");
    step();
    conv_req = 1'b1; conv_busy = 1'b1; n = cyc;
    exp_at(n + 1, 1, 1, 1, 0, "R7 busy blocks start");
    step(); quiet(); conv_busy = 1'b0;
    step();

    // R9: wake while awake
    request(2'b11); n = cyc;
    exp_at(n + 1, 1, 1, 1, 0, "R9 wake while awake");
    step(); quiet(); step();

    // R2: nap entry
    request(2'b01); n = cyc;
    exp_at(n + 1, 1, 1, 0, 0, "R2 nap accepted");
    exp_at(n + SETUP, 1, 1, 0, 0, "R2 before shutdown");
    exp_at(n + 1 + SETUP, 0, 1, 0, 0, "R2 shutdown falls");
    step(); quiet();
    step(SETUP + 1);
    // R8 and R9 while shut down
    conv_req = 1'b1; request(2'b10); n = cyc;
    exp_at(n + 1, 0, 1, 0, 0, "R8 R9 ignored while down");
    step(); quiet(); step();

    // R4: wake from nap
    request(2'b11); n = cyc;
    exp_at(n + 1, 1, 1, 0, 0, "R4 shutdown released");
    step(); quiet();
    conv_req = 1'b1;
    exp_at(n + 2, 1, 1, 0, 0, "R8 no start while waking");
    exp_at(n + NAPW, 1, 1, 0, 0, "R4 not ready early");
    exp_at(n + 1 + NAPW, 1, 1, 1, 0, "R4 ready after nap delay");
    step(); conv_req = 1'b0;
    step(NAPW + 1);

    // R3: sleep entry
    request(2'b10); n = cyc;
    exp_at(n + 1, 1, 0, 0, 0, "R3 sleep select");
    exp_at(n + SETUP, 1, 0, 0, 0, "R3 before shutdown");
    exp_at(n + 1 + SETUP, 0, 0, 0, 0, "R3 shutdown falls");
    exp_at(n + 3 + SETUP, 0, 0, 0, 0, "R3 select steady");
    step(); quiet();
    step(SETUP + 3);

    // R5: wake from sleep
    request(2'b11); n = cyc;
    exp_at(n + 1, 1, 0, 0, 0, "R5 shutdown released");
    exp_at(n + NAPW + 1, 1, 0, 0, 0, "R5 not ready at nap delay");
    exp_at(n + SLPW, 1, 0, 0, 0, "R5 not ready early");
    exp_at(n + 1 + SLPW, 1, 0, 1, 0, "R5 ready after sleep delay");
    step(); quiet();
    step(SLPW + 1);

    // R6: request held while busy
    conv_busy = 1'b1; request(2'b01); n = cyc;
    exp_at(n + 1, 1, 0, 1, 0, "R6 held while busy");
    exp_at(n + 3, 1, 0, 1, 0, "R6 still held");
    step(); quiet();
    step(2);
    conv_busy = 1'b0;
    exp_at(n + 4, 1, 1, 0, 0, "R6 acted after busy clears");
    exp_at(n + 4 + SETUP, 0, 1, 0, 0, "R6 shutdown falls");
    step(SETUP + 2);

    // wake from nap, then a start colliding with a shutdown
    request(2'b11); n = cyc;
    step(); quiet();
    step(NAPW);
    exp_at(n + 1 + NAPW, 1, 1, 1, 0, "R4 ready again");
    request(2'b01); conv_req = 1'b1; n = cyc;
    exp_at(n + 1, 1, 1, 0, 0, "R7 no start with shutdown");
    step(); quiet();
    step(SETUP + 3);

    if (q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    report();
  end
endmodule